// File: doc/BRIEF.md
# AXI Clock-Request Transaction Gate

This block sits between an AXI master and a memory slave whose clock can be switched off. It watches the read and write address channels. When an address arrives while the memory clock is stopped, the block does not let the transfer through. Instead it raises a clock request toward the clock controller and waits for an acknowledge that says the clock is stable. Only then does it open the address channels. While the clock is already running, addresses pass straight through without any request cycle.

The gate keeps a count of transfers that have not finished yet. An address handshake adds one. A write response, or the last beat of a read burst, takes one away. Once the gate has seen a programmable number of quiet cycles with nothing outstanding, it enters a one-cycle drain step. In that step it releases the request, unless a new address turns up, in which case it goes back to running. An optional watchdog flags an acknowledge that is taking too long. Address, data and response payloads are routed around the gate. The gate only handles the valid and ready qualifiers of the two address channels, and it only observes the response handshakes.

Top module: `axi_clkreq_gate`

## Requirements
- R1: After reset, `clk_req`, `s_awready`, `s_arready`, `m_awvalid`, `m_arvalid` and `ack_timeout` are all low.
- R2: With the gate off and the synchronized acknowledge low, a valid on either address channel raises `clk_req` at the next clock edge.
- R3: While the gate is off or waiting for the acknowledge, `m_awvalid`, `m_arvalid`, `s_awready` and `s_arready` stay low, even when the slave is ready.
- R4: `clk_ack` passes through a two-flop synchronizer. If `clk_ack` is high at edge k, the address channels open after edge k+2, and not earlier.
- R5: While running, each address valid goes to the slave and each slave ready goes back to the master in the same cycle, and `clk_req` stays high.
- R6: The outstanding count rises by one for each downstream address handshake (two when AW and AR complete in the same cycle). It falls by one for each B handshake and for each R handshake with `rlast` high. An R beat with `rlast` low leaves the count unchanged.
- R7: While running, after L consecutive cycles in which nothing is outstanding and no address valid is present (an `idle_limit` of 0 counts as 1), the gate enters the drain step. If no valid is present there, `clk_req` falls at the following edge, L+1 edges after the last busy edge.
- R8: `clk_req` is never low while the outstanding count is non-zero.
- R9: An address valid present during the drain step returns the gate to running. The channels stay open and `clk_req` stays high.
- R10: After the request is released, a new request is not raised until the synchronized acknowledge has fallen. This happens at the third edge after `clk_ack` falls.
- R11: With the timeout enabled, `ack_timeout` is high while the gate has waited at least `to_limit` edges for the acknowledge since entering the wait. It is low in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interconnect clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idle_limit | input | IDLE_W | Quiet cycles before the drain step (0 counts as 1) |
| to_limit | input | TO_W | Acknowledge wait limit in cycles |
| s_awvalid | input | 1 | Write address valid from the master |
| s_awready | output | 1 | Write address ready to the master |
| s_arvalid | input | 1 | Read address valid from the master |
| s_arready | output | 1 | Read address ready to the master |
| m_awvalid | output | 1 | Write address valid to the slave |
| m_awready | input | 1 | Write address ready from the slave |
| m_arvalid | output | 1 | Read address valid to the slave |
| m_arready | input | 1 | Read address ready from the slave |
| bvalid | input | 1 | Observed write response valid |
| bready | input | 1 | Observed write response ready |
| rvalid | input | 1 | Observed read data valid |
| rready | input | 1 | Observed read data ready |
| rlast | input | 1 | Observed last read beat flag |
| clk_req | output | 1 | Clock enable request to the clock controller |
| clk_ack | input | 1 | Clock stable acknowledge (asynchronous level) |
| ack_timeout | output | 1 | Acknowledge wait exceeded `to_limit` |

## Verification
The bench sweeps both address channels against acknowledge delays of zero to three cycles, and ties the idle limit to the delay so that the zero limit is also covered. It checks the exact edge where the channels open and the exact edge where the request drops. A gate that skipped a synchronizer stage, or miscounted idle cycles, would open or release one edge off.

A non-final read beat, and AW and AR completing in the same cycle, are each followed by long quiet stretches. A counter that stepped on every R beat, or missed the double increment, would drop the request with work still pending.

The bench also places an address in the drain cycle, which an eager release would lose. It issues a request while the old acknowledge is still high, which a gate that ignored the four-phase return would accept early. Finally, it walks the timeout flag across its threshold.

// File: rtl/gate_pkg.sv
package gate_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_REQ   = 2'd1,
    ST_RUN   = 2'd2,
    ST_DRAIN = 2'd3
  } gate_st_e;
endpackage

// File: rtl/cg_sync2.sv
module cg_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      q  <= 1'b0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/cg_outstanding.sv
module cg_outstanding #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_aw,
  input  logic             up_ar,
  input  logic             dn_b,
  input  logic             dn_r,
  output logic [CNT_W-1:0] count,
  output logic             zero
);
  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] cur,
                                            input logic a, input logic b,
                                            input logic c, input logic d);
    logic [1:0] up;
    logic [1:0] dn;
    up = {1'b0, a} + {1'b0, b};
    dn = {1'b0, c} + {1'b0, d};
    return cur + CNT_W'(up) - CNT_W'(dn);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= step(count, up_aw, up_ar, dn_b, dn_r);
  end

  assign zero = (count == '0);
endmodule

// File: rtl/cg_ctrl.sv
module cg_ctrl
  import gate_pkg::*;
#(
  parameter int IDLE_W     = 8,
  parameter int TO_W       = 8,
  parameter bit TIMEOUT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              access,
  input  logic              busy,
  input  logic              ack_s,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic [TO_W-1:0]   to_limit,
  output gate_st_e          state,
  output logic              gate_open,
  output logic              clk_req,
  output logic              ack_timeout
);
  gate_st_e          nxt;
  logic [IDLE_W-1:0] idle_cnt;
  logic              idle_done;

  function automatic logic idle_hit(input logic [IDLE_W-1:0] cnt,
                                    input logic [IDLE_W-1:0] lim);
    logic [IDLE_W:0] eff;
    eff = (lim == '0) ? (IDLE_W+1)'(1) : {1'b0, lim};
    return ({1'b0, cnt} + (IDLE_W+1)'(1)) >= eff;
  endfunction

  assign idle_done = !busy && idle_hit(idle_cnt, idle_limit);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_OFF:   if (access && !ack_s) nxt = ST_REQ;
      ST_REQ:   if (ack_s)            nxt = ST_RUN;
      ST_RUN:   if (idle_done)        nxt = ST_DRAIN;
      ST_DRAIN: nxt = access ? ST_RUN : ST_OFF;
      default:  nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_OFF;
      idle_cnt <= '0;
    end else begin
      state <= nxt;
      if (state == ST_RUN && !busy && !idle_done) idle_cnt <= idle_cnt + 1'b1;
      else                                        idle_cnt <= '0;
    end
  end

  assign gate_open = (state == ST_RUN) || (state == ST_DRAIN);
  assign clk_req   = (state != ST_OFF);

  generate
    if (TIMEOUT_EN) begin : g_to
      logic [TO_W-1:0] wait_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    wait_cnt <= '0;
        else if (state == ST_REQ && wait_cnt != '1)    wait_cnt <= wait_cnt + 1'b1;
        else if (state != ST_REQ)                      wait_cnt <= '0;
      end
      assign ack_timeout = (state == ST_REQ) && (wait_cnt >= to_limit);
    end else begin : g_no_to
      assign ack_timeout = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/axi_clkreq_gate.sv
module axi_clkreq_gate
  import gate_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int IDLE_W     = 8,
  parameter int TO_W       = 8,
  parameter bit TIMEOUT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic [TO_W-1:0]   to_limit,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic              m_arvalid,
  input  logic              m_arready,
  input  logic              bvalid,
  input  logic              bready,
  input  logic              rvalid,
  input  logic              rready,
  input  logic              rlast,
  output logic              clk_req,
  input  logic              clk_ack,
  output logic              ack_timeout
);
  logic             ack_sync;
  logic             access;
  logic             gate_open;
  logic             aw_hs, ar_hs, b_hs, rl_hs;
  logic [CNT_W-1:0] outst;
  logic             outst_zero;
  gate_st_e         state;

  assign access    = s_awvalid | s_arvalid;
  assign m_awvalid = s_awvalid & gate_open;
  assign m_arvalid = s_arvalid & gate_open;
  assign s_awready = m_awready & gate_open;
  assign s_arready = m_arready & gate_open;

  assign aw_hs = m_awvalid & m_awready;
  assign ar_hs = m_arvalid & m_arready;
  assign b_hs  = bvalid & bready;
  assign rl_hs = rvalid & rready & rlast;

  cg_sync2 u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (clk_ack),
    .q    (ack_sync)
  );

  cg_outstanding #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .up_aw(aw_hs),
    .up_ar(ar_hs),
    .dn_b (b_hs),
    .dn_r (rl_hs),
    .count(outst),
    .zero (outst_zero)
  );

  cg_ctrl #(.IDLE_W(IDLE_W), .TO_W(TO_W), .TIMEOUT_EN(TIMEOUT_EN)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .access     (access),
    .busy       (access | ~outst_zero),
    .ack_s      (ack_sync),
    .idle_limit (idle_limit),
    .to_limit   (to_limit),
    .state      (state),
    .gate_open  (gate_open),
    .clk_req    (clk_req),
    .ack_timeout(ack_timeout)
  );
endmodule

// File: rtl/axi_clkreq_gate_chk.sv
module axi_clkreq_gate_chk
  import gate_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_awvalid,
  input logic             s_arvalid,
  input logic             s_awready,
  input logic             s_arready,
  input logic             m_awvalid,
  input logic             m_arvalid,
  input logic             m_awready,
  input logic             m_arready,
  input logic             bvalid,
  input logic             bready,
  input logic             rvalid,
  input logic             rready,
  input logic             rlast,
  input logic             clk_req,
  input logic             ack_sync,
  input logic             ack_timeout,
  input logic [CNT_W-1:0] outst,
  input gate_st_e         state
);
  p_req_on_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OFF && (s_awvalid || s_arvalid) && !ack_sync) |=> clk_req);

  p_hold_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_req || state == ST_REQ) |-> (!m_awvalid && !m_arvalid && !s_awready && !s_arready));

  p_open_needs_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_awready || s_arready) |-> (ack_sync && clk_req));

  p_cnt_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(m_awvalid && m_awready) && !(m_arvalid && m_arready) &&
     !(bvalid && bready) && !(rvalid && rready && rlast)) |=> $stable(outst));

  p_busy_keeps_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (outst != '0) |-> clk_req);

  p_drain_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAIN && (s_awvalid || s_arvalid)) |=> (state == ST_RUN && clk_req));

  p_no_early_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OFF && ack_sync) |=> !clk_req);

  p_timeout_in_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_timeout |-> (state == ST_REQ));
endmodule

bind axi_clkreq_gate axi_clkreq_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_awvalid  (s_awvalid),
  .s_arvalid  (s_arvalid),
  .s_awready  (s_awready),
  .s_arready  (s_arready),
  .m_awvalid  (m_awvalid),
  .m_arvalid  (m_arvalid),
  .m_awready  (m_awready),
  .m_arready  (m_arready),
  .bvalid     (bvalid),
  .bready     (bready),
  .rvalid     (rvalid),
  .rready     (rready),
  .rlast      (rlast),
  .clk_req    (clk_req),
  .ack_sync   (ack_sync),
  .ack_timeout(ack_timeout),
  .outst      (outst),
  .state      (state)
);

// File: tb/test_axi_clkreq_gate.sv
`timescale 1ns/1ps
module test_axi_clkreq_gate;
  localparam int CNT_W  = 3;
  localparam int IDLE_W = 4;
  localparam int TO_W   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IDLE_W-1:0] idle_limit = '0;
  logic [TO_W-1:0]   to_limit = 4'd3;
  logic s_awvalid = 0, s_arvalid = 0, m_awready = 0, m_arready = 0;
  logic bvalid = 0, bready = 0, rvalid = 0, rready = 0, rlast = 0;
  logic clk_ack = 0;
  logic s_awready, s_arready, m_awvalid, m_arvalid, clk_req, ack_timeout;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  axi_clkreq_gate #(.CNT_W(CNT_W), .IDLE_W(IDLE_W), .TO_W(TO_W), .TIMEOUT_EN(1'b1)) i_axi_clkreq_gate (
    .clk(clk), .rst_n(rst_n), .idle_limit(idle_limit), .to_limit(to_limit),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .bvalid(bvalid), .bready(bready), .rvalid(rvalid), .rready(rready), .rlast(rlast),
    .clk_req(clk_req), .clk_ack(clk_ack), .ack_timeout(ack_timeout)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 20000 && !done) begin
      done = 1;
      mismatched = mismatched + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    compared = compared + 1;
    if (act != exp) begin
      mismatched = mismatched + 1;
      $display("FAIL %s: act=%0d exp=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic drive_valid(input int ch, input logic v);
    if (ch == 0) s_awvalid = v; else s_arvalid = v;
  endtask

  function automatic int mv(input int ch);
    return (ch == 0) ? int'(m_awvalid) : int'(m_arvalid);
  endfunction

  function automatic int sr(input int ch);
    return (ch == 0) ? int'(s_awready) : int'(s_arready);
  endfunction

  // Off -> request -> open, with the ack raised d cycles after the request
  task automatic wake(input int ch, input int d);
    m_awready = 1; m_arready = 1;
    drive_valid(ch, 1'b1);
    #1;
    check("R2 no request before edge", clk_req, 0);
    check("R3 valid blocked while off", mv(ch), 0);
    check("R3 ready blocked while off", sr(ch), 0);
    tick();
    check("R2 request raised", clk_req, 1);
    check("R3 valid blocked while waiting", mv(ch), 0);
    for (int i = 0; i < d; i++) begin
      tick();
      check("R3 held during wait", mv(ch) + sr(ch), 0);
    end
    clk_ack = 1;
    tick();
    check("R4 closed at edge k", mv(ch), 0);
    tick();
    check("R4 closed at edge k+1", sr(ch), 0);
    tick();
    check("R4 valid open at edge k+2", mv(ch), 1);
    check("R4 ready open at edge k+2", sr(ch), 1);
  endtask

  // Request must stay for eff quiet edges and drop at the next one
  task automatic expect_release(input int lim);
    int eff;
    eff = (lim == 0) ? 1 : lim;
    for (int i = 0; i < eff; i++) begin
      tick();
      check("R7 request held through idle window", clk_req, 1);
    end
    tick();
    check("R7 request released", clk_req, 0);
  endtask

  task automatic ack_down();
    clk_ack = 0;
    repeat (3) tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 clk_req reset", clk_req, 0);
    check("R1 readies reset", int'(s_awready) + int'(s_arready), 0);
    check("R1 valids reset", int'(m_awvalid) + int'(m_arvalid), 0);
    check("R1 timeout reset", ack_timeout, 0);
    rst_n = 1;
    tick();
    to_limit = 4'd15;

    // Sweep: channel x ack delay, idle limit tied to the delay (0..3)
    for (int ch = 0; ch < 2; ch++) begin
      for (int d = 0; d < 4; d++) begin
        int eff;
        eff = (d == 0) ? 1 : d;
        idle_limit = IDLE_W'(d);
        wake(ch, d);
        tick();                        // address handshake
        drive_valid(ch, 1'b0);
        if (ch == 0) begin
          bvalid = 1; bready = 1;
          tick();
          bvalid = 0;
        end else begin
          rvalid = 1; rready = 1; rlast = 0;
          tick();                      // non-final beat: count unchanged
          rvalid = 0;
          for (int i = 0; i < eff + 2; i++) begin
            tick();
            check("R6 non-last beat keeps transfer pending", clk_req, 1);
          end
          rvalid = 1; rlast = 1;
          tick();
          rvalid = 0; rlast = 0;
        end
        expect_release(d);
        ack_down();
      end
    end

    // Pass-through while running and AW+AR in one cycle
    idle_limit = 4'd1;
    wake(1, 1);
    m_arready = 0;
    #1;
    check("R5 slave ready low passes back", s_arready, 0);
    check("R5 valid passes while slave busy", m_arvalid, 1);
    m_arready = 1;
    s_awvalid = 1; m_awready = 1;
    #1;
    check("R5 aw valid passes", m_awvalid, 1);
    check("R5 aw ready passes", s_awready, 1);
    check("R5 request unchanged", clk_req, 1);
    tick();                            // both handshakes: count 2
    s_awvalid = 0; s_arvalid = 0;
    bvalid = 1; bready = 1;
    tick();                            // count 1
    bvalid = 0;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R8 request held with read still pending", clk_req, 1);
    end
    rvalid = 1; rready = 1; rlast = 1;
    tick();
    rvalid = 0; rlast = 0;
    expect_release(1);
    ack_down();

    // Access arriving in the drain step
    idle_limit = 4'd2;
    wake(0, 0);
    tick();
    s_awvalid = 0;
    bvalid = 1; bready = 1;
    tick();
    bvalid = 0;
    tick();
    tick();                            // now in the drain step
    s_arvalid = 1; m_arready = 0;
    #1;
    check("R9 channel open in drain step", m_arvalid, 1);
    tick();
    check("R9 request kept by late access", clk_req, 1);
    check("R9 channel still open", m_arvalid, 1);
    s_arvalid = 0;
    expect_release(2);

    // Request while the old acknowledge is still synchronized high
    clk_ack = 0;
    s_awvalid = 1; m_awready = 1;
    to_limit = 4'd3;
    tick();
    check("R10 no request at first edge", clk_req, 0);
    tick();
    check("R10 no request at second edge", clk_req, 0);
    tick();
    check("R10 request at third edge", clk_req, 1);
    check("R11 no timeout at wait entry", ack_timeout, 0);
    tick();
    check("R11 no timeout after 1", ack_timeout, 0);
    tick();
    check("R11 no timeout after 2", ack_timeout, 0);
    tick();
    check("R11 timeout at limit", ack_timeout, 1);
    tick();
    check("R11 timeout holds", ack_timeout, 1);
    clk_ack = 1;
    tick();
    tick();
    check("R11 timeout while still waiting", ack_timeout, 1);
    tick();
    check("R11 timeout cleared on open", ack_timeout, 0);
    check("R4 open after late ack", m_awvalid, 1);
    tick();
    s_awvalid = 0;
    bvalid = 1; bready = 1;
    tick();
    bvalid = 0;
    expect_release(2);
    ack_down();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule